// File: doc/BRIEF.md
# Deep Power-Down Sequencer for Low-Power DDR

This block sits between the command scheduler of a memory controller and a low-power DDR device. It takes the device into its deepest sleep state and brings it back out. The scheduler asks for sleep with `dpd_req`. The block waits until every bank is idle, the data bus is quiet and the row-precharge time has run out since the most recent precharge. It then drives the sleep command for one cycle with the clock enable low. The clock enable stays low for as long as the device sleeps.

A wake request is served only while the clock is reported stable. The block raises the clock enable with a NOP and keeps the command bus on NOP for a programmable stabilization window, which is 200 µs worth of clocks by default. It then gives an external initialization sequencer a single-cycle start pulse, and that sequencer carries out the precharge-all and the full device setup. The block also keeps a sticky flag saying that the memory contents are no longer valid, because the array is unpowered while it sleeps.

While the block owns the command bus it asserts `cmd_own`, and the scheduler muxes the block's command pins onto the bus during that time. Clock generation and the initialization steps themselves belong to other blocks.

Top module: `lpddr_dpd_ctrl`

## Requirements
- R1: After reset, cke is 1, the command pins are all 1 (deselect), and in_dpd, cmd_own, data_lost and init_start are all 0.
- R2: The sleep command is issued only when three conditions hold at the sampling edge: banks_idle is 1, bus_busy is 0, and no precharge is marked by pre_seen in that cycle or in the TRP_CYC edges before it. Suppose a precharge is sampled at edge P and a request at edge P+d, with the bank and bus conditions holding. The command then appears after edge max(P+d, P+TRP_CYC+1), and it appears after no earlier edge.
- R3: A request that arrives while the entry conditions fail is kept pending, even as a one-cycle pulse. Entry happens after the first edge at which the conditions hold.
- R4: The sleep command lasts exactly one cycle. It is cs_n=0, ras_n=1, cas_n=1, we_n=0 with cke=0.
- R5: From the sleep command until the exit, cke stays 0. After the sleep-command cycle the pins show deselect (all 1).
- R6: A wake_req received during sleep is remembered. The exit starts after the first edge at which clk_stable is 1 and a wake is pending or present.
- R7: At the exit, cke rises together with a NOP (cs_n=0, ras_n=cas_n=we_n=1). cke stays 1 with NOP for exactly STAB_CYC cycles.
- R8: After the window, init_start is 1 for exactly one cycle and cmd_own drops to 0. The block waits in this state until init_done. dpd_req is ignored during this state and is not kept pending.
- R9: data_lost becomes 1 in the cycle of the sleep command and stays 1 until reset.
- R10: in_dpd is 1 from the sleep-command cycle until cke rises. cmd_own is 1 from the sleep command through the last cycle of the stabilization window.
- R11: A wake_req received while the block is not in or entering sleep has no effect. It does not change the outputs and is not remembered for a later sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| dpd_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| clk_stable | input | 1 | Device clock is running and stable |
| banks_idle | input | 1 | All banks are precharged |
| bus_busy | input | 1 | A data burst is still in flight |
| pre_seen | input | 1 | Scheduler issues a precharge this cycle |
| init_done | input | 1 | External init sequencer has finished |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| in_dpd | output | 1 | Status: device is entering or in deep power-down |
| cmd_own | output | 1 | Block drives the command bus |
| data_lost | output | 1 | Memory contents are invalid (sticky) |
| init_start | output | 1 | One-cycle start pulse to the init sequencer |

## Verification
Several properties are checked on every cycle. A sleep command only follows a cycle in which the idle, quiet-bus and precharge-time conditions held. cke is low whenever the status flag is high. A rising cke always carries a NOP and comes only after a stable-clock cycle in sleep. The init pulse never lasts two cycles, and the lost-data flag never clears. Other behaviour can only be shown by the bench's scenarios. These scenarios sweep the distance between precharge and request and check the exact entry cycle. They also cover a request kept pending across busy cycles, a wake held back by an unstable clock, the exact length of the NOP window, and requests that must be ignored while idle or during re-initialization.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_TRP,
    ST_ENTER,
    ST_IN_DPD,
    ST_EXIT_WAIT,
    ST_REINIT_REQ
  } dpd_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_SLEEP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

endpackage

// File: rtl/dpd_trp_tracker.sv
module dpd_trp_tracker #(
  parameter int unsigned TRP_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pre_seen,
  output logic trp_met
);
  localparam int unsigned CW = $clog2(TRP_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(TRP_CYC);

  logic [CW-1:0] since_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pre <= CNT_MAX;
    end else if (pre_seen) begin
      since_pre <= '0;
    end else if (since_pre != CNT_MAX) begin
      since_pre <= since_pre + 1'b1;
    end
  end

  // a precharge in the current cycle restarts the window, so it also blocks entry
  assign trp_met = (since_pre == CNT_MAX) && !pre_seen;

  AST_TRP_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    since_pre <= CNT_MAX); // R2

  AST_TRP_RESTART: assert property (@(posedge clk) disable iff (rst)
    pre_seen |=> (since_pre == '0)); // R2

endmodule

// File: rtl/dpd_stab_timer.sv
module dpd_stab_timer #(
  parameter int unsigned STAB_CYC = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  logic [CW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      elapsed <= '0;
    end else if (run && (elapsed != LAST)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign done = run && (elapsed == LAST);

  AST_STAB_BOUND: assert property (@(posedge clk) disable iff (rst)
    elapsed <= LAST); // R7

endmodule

// File: rtl/dpd_seq_fsm.sv
module dpd_seq_fsm
  import dpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dpd_req,
  input  logic       wake_req,
  input  logic       clk_stable,
  input  logic       banks_idle,
  input  logic       bus_busy,
  input  logic       trp_met,
  input  logic       stab_done,
  input  logic       init_done,
  output dpd_state_e state,
  output dpd_state_e nxt
);
  logic entry_ok;
  logic wake_pend;
  logic wake_any;

  assign entry_ok = banks_idle && !bus_busy && trp_met;
  assign wake_any = wake_pend || wake_req;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:       if (dpd_req) nxt = entry_ok ? ST_ENTER : ST_WAIT_TRP;
      ST_WAIT_TRP:   if (entry_ok) nxt = ST_ENTER;
      ST_ENTER:      nxt = ST_IN_DPD;
      ST_IN_DPD:     if (wake_any && clk_stable) nxt = ST_EXIT_WAIT;
      ST_EXIT_WAIT:  if (stab_done) nxt = ST_REINIT_REQ;
      ST_REINIT_REQ: if (init_done) nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wake_pend <= 1'b0;
    end else begin
      state     <= nxt;
      wake_pend <= ((state == ST_ENTER) || (state == ST_IN_DPD)) &&
                   (nxt != ST_EXIT_WAIT) && wake_any;
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_TRP) |=> (state == ST_WAIT_TRP) || (state == ST_ENTER)); // R3

  AST_ENTER_ONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENTER) |=> (state == ST_IN_DPD)); // R4

endmodule

// File: rtl/dpd_out_reg.sv
module dpd_out_reg
  import dpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpd_state_e state,
  input  dpd_state_e nxt,
  output logic       cke,
  output dram_cmd_t  cmd,
  output logic       in_dpd,
  output logic       cmd_own,
  output logic       data_lost,
  output logic       init_start
);
  logic      asleep_d;
  dram_cmd_t cmd_d;

  assign asleep_d = (nxt == ST_ENTER) || (nxt == ST_IN_DPD);

  always_comb begin
    cmd_d = CMD_DESEL;
    if (nxt == ST_ENTER)          cmd_d = CMD_SLEEP;
    else if (nxt == ST_EXIT_WAIT) cmd_d = CMD_NOP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke        <= 1'b1;
      cmd        <= CMD_DESEL;
      in_dpd     <= 1'b0;
      cmd_own    <= 1'b0;
      data_lost  <= 1'b0;
      init_start <= 1'b0;
    end else begin
      cke        <= !asleep_d;
      cmd        <= cmd_d;
      in_dpd     <= asleep_d;
      cmd_own    <= asleep_d || (nxt == ST_EXIT_WAIT);
      data_lost  <= data_lost || (nxt == ST_ENTER);
      init_start <= (nxt == ST_REINIT_REQ) && (state != ST_REINIT_REQ);
    end
  end

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
    data_lost |=> data_lost); // R9

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    init_start |=> !init_start); // R8

endmodule

// File: rtl/lpddr_dpd_ctrl.sv
module lpddr_dpd_ctrl
  import dpd_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned STAB_US  = 200,
  parameter int unsigned STAB_CYC = CLK_MHZ * STAB_US,
  parameter int unsigned TRP_CYC  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic dpd_req,
  input  logic wake_req,
  input  logic clk_stable,
  input  logic banks_idle,
  input  logic bus_busy,
  input  logic pre_seen,
  input  logic init_done,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic in_dpd,
  output logic cmd_own,
  output logic data_lost,
  output logic init_start
);
  dpd_state_e state;
  dpd_state_e nxt;
  logic       trp_met;
  logic       stab_done;
  logic       stab_clear;
  logic       stab_run;
  dram_cmd_t  cmd;

  assign stab_clear = (nxt == ST_EXIT_WAIT) && (state != ST_EXIT_WAIT);
  assign stab_run   = (state == ST_EXIT_WAIT);

  dpd_trp_tracker #(.TRP_CYC(TRP_CYC)) trp_i (
    .clk     (clk),
    .rst     (rst),
    .pre_seen(pre_seen),
    .trp_met (trp_met)
  );

  dpd_stab_timer #(.STAB_CYC(STAB_CYC)) stab_i (
    .clk  (clk),
    .rst  (rst),
    .clear(stab_clear),
    .run  (stab_run),
    .done (stab_done)
  );

  dpd_seq_fsm fsm_i (
    .clk       (clk),
    .rst       (rst),
    .dpd_req   (dpd_req),
    .wake_req  (wake_req),
    .clk_stable(clk_stable),
    .banks_idle(banks_idle),
    .bus_busy  (bus_busy),
    .trp_met   (trp_met),
    .stab_done (stab_done),
    .init_done (init_done),
    .state     (state),
    .nxt       (nxt)
  );

  dpd_out_reg out_i (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .nxt       (nxt),
    .cke       (cke),
    .cmd       (cmd),
    .in_dpd    (in_dpd),
    .cmd_own   (cmd_own),
    .data_lost (data_lost),
    .init_start(init_start)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

  AST_ENTRY_GUARD: assert property (@(posedge clk) disable iff (rst)
    (!cke && !cs_n && !we_n) |-> $past(banks_idle && !bus_busy && trp_met)); // R2

  AST_CKE_LOW_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    in_dpd |-> !cke); // R5

  AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n)); // R7

  AST_EXIT_CLK_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(clk_stable)); // R6

  AST_LOST_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> data_lost); // R9

endmodule

// File: tb/lpddr_dpd_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpddr_dpd_ctrl_tb_top;
  localparam int TRP = 4;
  localparam int STAB = 20;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_SLP = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dpd_req = 0, wake_req = 0, clk_stable = 1, banks_idle = 1;
  logic bus_busy = 0, pre_seen = 0, init_done = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, in_dpd, cmd_own, data_lost, init_start;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  lpddr_dpd_ctrl #(.STAB_CYC(STAB), .TRP_CYC(TRP)) dut_i (
    .clk(clk), .rst(rst), .dpd_req(dpd_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle), .bus_busy(bus_busy),
    .pre_seen(pre_seen), .init_done(init_done), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .in_dpd(in_dpd),
    .cmd_own(cmd_own), .data_lost(data_lost), .init_start(init_start)
  );

  // observed vector: cke, cmd[3:0], in_dpd, cmd_own, data_lost, init_start
  function automatic logic [8:0] obs();
    return {cke, cs_n, ras_n, cas_n, we_n, in_dpd, cmd_own, data_lost, init_start};
  endfunction

  function automatic logic [8:0] ev(logic k, logic [3:0] c, logic d, logic o, logic l, logic s);
    return {k, c, d, o, l, s};
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 reset state", obs(), ev(1, C_DES, 0, 0, 0, 0));
    rst = 0;
    step();
    chk("R1 idle after reset", obs(), ev(1, C_DES, 0, 0, 0, 0));

    // R11: wake while idle does nothing and is not remembered
    wake_req = 1; step(); wake_req = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 idle wake ignored", obs(), ev(1, C_DES, 0, 0, 0, 0));
    end

    // R3: one-cycle request while banks busy stays pending
    banks_idle = 0; dpd_req = 1; step(); dpd_req = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 no entry while banks busy", obs(), ev(1, C_DES, 0, 0, 0, 0));
    end
    banks_idle = 1; bus_busy = 1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R2 no entry while bus busy", obs(), ev(1, C_DES, 0, 0, 0, 0));
    end
    bus_busy = 0; step();
    chk("R3 R4 pending request enters", obs(), ev(0, C_SLP, 1, 1, 1, 0));
    // R11 follow-up: stable clock, no wake remembered from idle
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 R5 stays asleep", obs(), ev(0, C_DES, 1, 1, 1, 0));
    end
    wake_req = 1; step(); wake_req = 0;
    chk("R7 exit NOP cke high", obs(), ev(1, C_NOP, 0, 1, 1, 0));
    for (int k = 1; k < STAB; k++) begin
      step();
      chk("R7 stabilization window", obs(), ev(1, C_NOP, 0, 1, 1, 0));
    end
    step();
    chk("R8 init pulse", obs(), ev(1, C_DES, 0, 0, 1, 1));
    init_done = 1; step(); init_done = 0;
    chk("R8 R9 pulse ends", obs(), ev(1, C_DES, 0, 0, 1, 0));

    // sweep precharge-to-request distance d and wake delay
    for (int d = 0; d < 8; d++) begin
      int e;
      int w;
      e = (d > TRP + 1) ? d : TRP + 1;
      w = d % 3;
      step();
      pre_seen = 1;
      if (d == 0) dpd_req = 1;
      step(); // edge P
      pre_seen = 0; dpd_req = 0;
      for (int k = 1; k <= e; k++) begin
        if (k == d) dpd_req = 1;
        step();
        dpd_req = 0;
        if (k == e)
          chk($sformatf("R2 R4 R10 entry d=%0d", d), obs(), ev(0, C_SLP, 1, 1, 1, 0));
        else
          chk($sformatf("R2 early entry d=%0d", d), obs(), ev(1, C_DES, 0, 0, 1, 0));
      end
      step();
      chk("R5 asleep deselect", obs(), ev(0, C_DES, 1, 1, 1, 0));
      // R6: wake with unstable clock is held
      clk_stable = 0; wake_req = 1; step(); wake_req = 0;
      chk("R6 wake waits for clock", obs(), ev(0, C_DES, 1, 1, 1, 0));
      for (int i = 0; i < w; i++) begin
        step();
        chk("R6 R5 still asleep", obs(), ev(0, C_DES, 1, 1, 1, 0));
      end
      clk_stable = 1; step();
      chk("R6 R7 R10 exit on stable clock", obs(), ev(1, C_NOP, 0, 1, 1, 0));
      for (int k = 1; k < STAB; k++) begin
        step();
        chk("R7 window length", obs(), ev(1, C_NOP, 0, 1, 1, 0));
      end
      step();
      chk("R8 init start", obs(), ev(1, C_DES, 0, 0, 1, 1));
      dpd_req = 1; step(); dpd_req = 0;
      chk("R8 single pulse", obs(), ev(1, C_DES, 0, 0, 1, 0));
      step();
      chk("R8 waits for init done", obs(), ev(1, C_DES, 0, 0, 1, 0));
      init_done = 1; step(); init_done = 0;
      for (int i = 0; i < 2; i++) begin
        step();
        chk("R8 R9 request during reinit dropped", obs(), ev(1, C_DES, 0, 0, 1, 0));
      end
    end

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule